// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Configuration

This block is a watchdog that asks for a system reset when software stops servicing it. It counts pulses of a slow tick enable, nominally 1 kHz. If the count reaches the selected overflow value before software clears it, the block raises a reset request for one clock. Software services the watchdog by writing any value to a service address. That address is read-only status space, so the write carries no data into the block; only the address decode matters.

The enable bit and the timeout-select bit sit in an option register that accepts one write after each reset. That first write also restarts the count. After it, the settings stay fixed until the next reset, so a runaway program cannot switch the watchdog off.

The count holds still while the debug input is high. It is forced to zero for as long as the stop input is high. When the block fires, it returns itself to its reset defaults. A sticky flag records that the last reset came from the watchdog.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset (`por_n` low), `wd_rst_req` and `wd_rst_flag` are 0. The watchdog is enabled, the long timeout is selected and the option register is unlocked.
- R2: With select 0, the request is raised by the 2^LONG_LOG2-th tick (256 by default) counted from the last clear.
- R3: With select 1, the request is raised by the 2^SHORT_LOG2-th tick (32 by default). The option register takes select from `bus_wdata` bit 0 and enable from bit 1, at address OPT_ADDR (0x01).
- R4: The count advances only in clock cycles where `tick_1k` is high. Clocks without a tick leave it unchanged.
- R5: A write of any data to SVC_ADDR (0x00) clears the count and does not change `wd_rst_flag`.
- R6: Only the first write to OPT_ADDR after a reset is taken. Later writes have no effect until the next reset.
- R7: The first write to OPT_ADDR clears the count.
- R8: With enable 0 the block never raises a request.
- R9: While `dbg_mode` is high, ticks do not advance the count.
- R10: While `stop_mode` is high, the count is zero. Counting resumes from zero when it drops.
- R11: A request lasts exactly one clock. When it fires, the option register returns to its defaults and unlocks, and counting restarts from zero.
- R12: A request sets `wd_rst_flag`. The flag stays set until `por_n` or `ext_rst` clears it.
- R13: A service write in the same cycle as a tick leaves the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| ext_rst | input | 1 | Synchronous reset from another source |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | DATA_W | Bus write data |
| tick_1k | input | 1 | Slow tick enable, one clock wide |
| dbg_mode | input | 1 | Debug mode, freezes the count |
| stop_mode | input | 1 | Stop mode, holds the count at zero |
| wd_rst_req | output | 1 | One-clock reset request |
| wd_rst_flag | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
The bench sweeps every service point inside the short window and checks that each one restarts a full window. A design that cleared the count only partly, or fired on the old count, would request early. It tries a second option write of the opposite setting and a late disable attempt. A lock that failed would shift the timeout or silence the watchdog. It also drives a service write and a tick in the same cycle, ticks during debug and ticks during stop. These catch a wrong priority, which would leave a stray count of one, and a stop that pauses instead of clearing, which would fire early after stop ends. Finally it checks that a firing leaves the option register unlocked at its long default and that the flag survives service writes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic en;
    logic short_sel;
  } wd_opt_t;

  localparam wd_opt_t OPT_DEFAULT = '{en: 1'b1, short_sel: 1'b0};
endpackage

// File: rtl/wdog_optreg.sv
module wdog_optreg
  import wdog_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EN_BIT  = 1,
  parameter int SEL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output wd_opt_t           opt,
  output logic              first_wr
);
  wd_opt_t opt_q, opt_d;
  logic    locked_q, locked_d;
  logic    unused_bits;

  assign unused_bits = ^wdata;
  assign first_wr    = wr & ~locked_q;

  always_comb begin
    opt_d    = opt_q;
    locked_d = locked_q;
    if (clr) begin
      opt_d    = OPT_DEFAULT;
      locked_d = 1'b0;
    end else if (first_wr) begin
      opt_d.en        = wdata[EN_BIT];
      opt_d.short_sel = wdata[SEL_BIT];
      locked_d        = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q    <= OPT_DEFAULT;
      locked_q <= 1'b0;
    end else begin
      opt_q    <= opt_d;
      locked_q <= locked_d;
    end
  end

  assign opt = opt_q;

  p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr && !clr) |=> $stable(opt_q));
  p_defaults_after_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (opt_q == OPT_DEFAULT && !locked_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int LONG_LOG2  = 8,
  parameter int SHORT_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 hold,
  input  logic                 en,
  input  logic                 short_sel,
  input  logic                 tick,
  output logic                 fire,
  output logic [LONG_LOG2-1:0] cnt_o
);
  localparam int CW = LONG_LOG2;
  localparam logic [CW-1:0] SHORT_M1 = CW'((1 << SHORT_LOG2) - 1);
  localparam logic [CW-1:0] LONG_M1  = '1;

  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          adv, at_lim;

  assign lim_m1 = short_sel ? SHORT_M1 : LONG_M1;
  assign at_lim = (cnt_q == lim_m1);
  assign adv    = ~clr & ~hold & en & tick;
  assign fire   = adv & at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (adv)  cnt_d = at_lim ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_debug_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(cnt_q));
  p_no_tick_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
  p_within_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_m1);
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fire,
  output logic req,
  output logic flag
);
  logic req_q, req_d, flag_q, flag_d;

  always_comb begin
    req_d  = fire & ~clr;
    flag_d = flag_q;
    if (clr)       flag_d = 1'b0;
    else if (fire) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      flag_q <= flag_d;
    end
  end

  assign req  = req_q;
  assign flag = flag_q;

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  p_flag_with_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> flag_q);
  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 8'h01,
  parameter int              EN_BIT      = 1,
  parameter int              SEL_BIT     = 0,
  parameter int              LONG_LOG2   = 8,
  parameter int              SHORT_LOG2  = 5,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tick_1k,
  input  logic              dbg_mode,
  input  logic              stop_mode,
  output logic              wd_rst_req,
  output logic              wd_rst_flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_n;
  logic                   svc_wr, opt_wr, opt_first, fire, cnt_clr, opt_clr;
  wd_opt_t                opt;
  logic [LONG_LOG2-1:0]   cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_n = sync_q[SYNC_STAGES-1];

  assign svc_wr  = bus_we & (bus_addr == SVC_ADDR);
  assign opt_wr  = bus_we & (bus_addr == OPT_ADDR);
  assign opt_clr = ext_rst | fire;
  assign cnt_clr = ext_rst | stop_mode | svc_wr | opt_first;

  wdog_optreg #(.DATA_W(DATA_W), .EN_BIT(EN_BIT), .SEL_BIT(SEL_BIT)) u_opt (
    .clk(clk), .rst_n(rst_n), .clr(opt_clr), .wr(opt_wr), .wdata(bus_wdata),
    .opt(opt), .first_wr(opt_first)
  );

  wdog_counter #(.LONG_LOG2(LONG_LOG2), .SHORT_LOG2(SHORT_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .hold(dbg_mode), .en(opt.en),
    .short_sel(opt.short_sel), .tick(tick_1k), .fire(fire), .cnt_o(cnt)
  );

  wdog_status u_stat (
    .clk(clk), .rst_n(rst_n), .clr(ext_rst), .fire(fire),
    .req(wd_rst_req), .flag(wd_rst_flag)
  );

  p_stop_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> (cnt == '0));
  p_service_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    svc_wr |=> (cnt == '0));
  p_first_write_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    opt_first |=> (cnt == '0));
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !opt.en |=> !wd_rst_req);
  p_service_keeps_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && !ext_rst && !fire) |=> (wd_rst_flag == $past(wd_rst_flag)));
endmodule

// File: tb/wdog_top_test.sv
module wdog_top_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, ext_rst = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       tick_1k = 1'b0, dbg_mode = 1'b0, stop_mode = 1'b0;
  logic       wd_rst_req, wd_rst_flag;
  int         n_chk = 0, n_fail = 0;

  localparam int LONG_T  = 1 << 8;
  localparam int SHORT_T = 1 << 5;

  always #2 clk = ~clk;

  wdog_top uut (
    .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick_1k(tick_1k),
    .dbg_mode(dbg_mode), .stop_mode(stop_mode),
    .wd_rst_req(wd_rst_req), .wd_rst_flag(wd_rst_flag)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick_once(output bit fired);
    @(negedge clk) tick_1k = 1'b1;
    @(negedge clk) tick_1k = 1'b0;
    fired = wd_rst_req;
  endtask

  task automatic ticks(input int n);
    bit f;
    for (int i = 0; i < n; i++) tick_once(f);
  endtask

  task automatic count_to_fire(input int max, output int n);
    bit f;
    n = 0;
    for (int i = 1; i <= max; i++) begin
      tick_once(f);
      if (f) begin n = i; break; end
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) begin bus_we = 1'b1; bus_addr = a; bus_wdata = d; end
    @(negedge clk) bus_we = 1'b0;
  endtask

  task automatic do_ext_rst();
    @(negedge clk) ext_rst = 1'b1;
    @(negedge clk) ext_rst = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk) por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    bit f;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(wd_rst_req, 0, "R1 req");
    check(wd_rst_flag, 0, "R1 flag");
    // R2 default long timeout, R1 default enabled
    count_to_fire(LONG_T + 4, n);
    check(n, LONG_T, "R2 default long");
    check(wd_rst_flag, 1, "R12 flag set");
    @(negedge clk);
    check(wd_rst_req, 0, "R11 one cycle");
    // R11 self reset: long default again, option unlocked
    count_to_fire(LONG_T + 4, n);
    check(n, LONG_T, "R11 restart long");
    bus_write(8'h01, 8'h03);
    count_to_fire(SHORT_T + 4, n);
    check(n, SHORT_T, "R11 unlocked after fire");
    // R12 ext reset clears flag; R5 service keeps flag
    bus_write(8'h00, 8'hA5);
    check(wd_rst_flag, 1, "R5 flag kept");
    do_ext_rst();
    check(wd_rst_flag, 0, "R12 ext clears");
    // R3 short + R5 sweep of service points
    for (int k = 1; k < SHORT_T; k++) begin
      do_ext_rst();
      bus_write(8'h01, 8'h03);
      ticks(k);
      bus_write(8'h00, 8'(k));
      count_to_fire(SHORT_T + 4, n);
      check(n, SHORT_T, $sformatf("R5 service after %0d", k));
    end
    // R12 por clears flag
    check(wd_rst_flag, 1, "R12 flag before por");
    do_por();
    check(wd_rst_flag, 0, "R12 por clears");
    // R6 second write ignored
    bus_write(8'h01, 8'h03);
    bus_write(8'h01, 8'h02);
    bus_write(8'h01, 8'h00);
    count_to_fire(SHORT_T + 4, n);
    check(n, SHORT_T, "R6 later writes ignored");
    // R7 first write clears count
    do_ext_rst();
    ticks(100);
    bus_write(8'h01, 8'h02);
    count_to_fire(LONG_T + 4, n);
    check(n, LONG_T, "R7 first write clears");
    // R8 disabled
    do_ext_rst();
    bus_write(8'h01, 8'h01);
    count_to_fire(LONG_T + 50, n);
    check(n, 0, "R8 disabled never fires");
    check(wd_rst_flag, 0, "R8 flag stays clear");
    // R4 idle clocks
    do_ext_rst();
    bus_write(8'h01, 8'h03);
    ticks(20);
    repeat (60) @(negedge clk);
    count_to_fire(SHORT_T, n);
    check(n, SHORT_T - 20, "R4 only ticks count");
    // R9 debug hold
    do_ext_rst();
    bus_write(8'h01, 8'h03);
    ticks(10);
    dbg_mode = 1'b1;
    count_to_fire(40, n);
    check(n, 0, "R9 no fire in debug");
    dbg_mode = 1'b0;
    count_to_fire(SHORT_T, n);
    check(n, SHORT_T - 10, "R9 resumes held value");
    // R10 stop clears
    do_ext_rst();
    bus_write(8'h01, 8'h03);
    ticks(25);
    stop_mode = 1'b1;
    ticks(5);
    stop_mode = 1'b0;
    count_to_fire(SHORT_T + 4, n);
    check(n, SHORT_T, "R10 resume from zero");
    // R13 service with tick same cycle
    do_ext_rst();
    bus_write(8'h01, 8'h03);
    ticks(10);
    @(negedge clk) begin tick_1k = 1'b1; bus_we = 1'b1; bus_addr = 8'h00; end
    @(negedge clk) begin tick_1k = 1'b0; bus_we = 1'b0; end
    count_to_fire(SHORT_T + 4, n);
    check(n, SHORT_T, "R13 service wins over tick");
    tick_once(f);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule